// File: doc/BRIEF.md
# GPIO Pad Controller with Shared Interrupt Lines

This block is a memory-mapped controller for general-purpose pads arranged in groups. Each group has room for fifteen pads, and any group may fit fewer of them. Each pad has two 32-bit configuration words. The first word holds the synchronized receive level, the transmit level driven onto the pad, and a 4-bit selector. The selector names one of sixteen shared interrupt lines. The second word holds a 3-bit trigger code and a receive inversion bit.

Pad inputs pass through a two-flop synchronizer. A per-pad detector then turns the possibly inverted level into edge or level events. Each event sets the status bit of the line chosen by its pad's selector. Software clears status bits by writing ones to them, and an enable mask decides which lines drive the single registered interrupt output. All accesses use one 32-bit port with a write strobe and a read strobe. Read data appears one cycle after the read strobe.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After reset every configuration word, the status register, the mask register, `pad_out_o` and `irq_o` are zero.
- R2: Word 0 of pad p in group g is at 0x4400 + 1024*g + 8*p. Bit 1 of word 0 is stored and driven on `pad_out_o[g*15+p]`. Bit 0 is read-only and returns the pad input after two synchronizer flops. Bits 31:28 are the line selector. All other bits read as zero.
- R3: Word 1 sits 4 bytes above word 0. Bits 2:0 hold the trigger code and bit 6 holds receive inversion. Both fields read back as written, and all other bits read as zero.
- R4: With trigger code 2, a low-to-high change of the (possibly inverted) synchronized input sets the status bit whose index equals the pad's selector. A high-to-low change sets nothing.
- R5: With trigger code 1, only a high-to-low change sets the selected status bit.
- R6: With trigger code 3, changes in both directions set the selected status bit.
- R7: With trigger code 4, the selected status bit is set on every cycle the input is high, so a clear does not hold while the level persists. Once the input is low, a clear holds.
- R8: When bit 6 of word 1 is set, the input is inverted before detection, so level mode then fires while the pad is low.
- R9: The status register is at 0x300, bits 15:0. Writing a 1 clears a bit and writing a 0 leaves it unchanged. No bit drops without such a write.
- R10: The mask register is at 0x380, bits 15:0, and is read/write. `irq_o` equals the OR of (status AND mask), delayed by one register stage.
- R11: Writes to pads that a group does not fit have no effect. Reads of those pads and of unmapped offsets return zero, and `pad_out_o` for those pads stays zero.
- R12: Trigger codes 0, 5, 6 and 7 produce no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| addr_i | input | 16 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after `re_i` |
| pad_in_i | input | NUM_GROUPS*15 | Asynchronous pad inputs, index g*15+p |
| pad_out_o | output | NUM_GROUPS*15 | Transmit levels, index g*15+p |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that pad 0 of group 0 is fitted, that `addr_i` and `wdata_i` are stable while `we_i` is high at a clock edge, and that status bits change only through line events or clear writes. The stimulus moves every pad input and strobe at the falling clock edge. It holds each pad level for at least five cycles, so that the synchronizer, the detector, the status register and the interrupt register have all settled before anything is read back. The bench never issues a read and a write in the same cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PADS_MAX  = 15;
  localparam int LINES     = 16;
  localparam int SEL_W     = $clog2(LINES);
  localparam int ADDR_W    = 16;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 16'h0300;
  localparam logic [ADDR_W-1:0] MASK_ADDR = 16'h0380;
  localparam logic [ADDR_W-1:0] PAD_BASE  = 16'h4400;
  localparam int GROUP_STRIDE = 1024;
  localparam int PAD_STRIDE   = 8;

  typedef enum logic [2:0] {
    TRIG_OFF   = 3'd0,
    TRIG_FALL  = 3'd1,
    TRIG_RISE  = 3'd2,
    TRIG_BOTH  = 3'd3,
    TRIG_LEVEL = 3'd4
  } trig_e;

  function automatic logic [ADDR_W-1:0] pad_cfg_addr(input int g, input int p);
    return PAD_BASE + ADDR_W'(g * GROUP_STRIDE) + ADDR_W'(p * PAD_STRIDE);
  endfunction
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_pad_event.sv
module gpio_pad_event
  import gpio_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  input  logic       inv_i,
  input  logic [2:0] mode_i,
  output logic       evt_o
);
  logic lvl, prev_q, rise, fall;

  assign lvl = rx_i ^ inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

  always_comb begin
    unique case (mode_i)
      TRIG_FALL:  evt_o = fall;
      TRIG_RISE:  evt_o = rise;
      TRIG_BOTH:  evt_o = rise | fall;
      TRIG_LEVEL: evt_o = lvl;
      default:    evt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] status_q, mask_q, clr;
  logic         irq_q;

  assign clr = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr) | set_i;
      if (mask_we_i) mask_q <= wdata_i;
      irq_q <= |(status_q & mask_q);
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_GROUPS = 3,
  parameter logic [NUM_GROUPS*4-1:0] GROUP_PADS = 12'h9F8,
  localparam int NPAD = NUM_GROUPS * PADS_MAX
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NPAD-1:0]   pad_in_i,
  output logic [NPAD-1:0]   pad_out_o,
  output logic              irq_o
);
  logic [NPAD-1:0]  rx_sync, hit0, hit1, tx_vec, inv_vec, evt;
  logic [SEL_W-1:0] sel_arr  [NPAD];
  logic [2:0]       mode_arr [NPAD];
  logic [LINES-1:0] line_set, stat_q, mask_q;
  logic [31:0]      rdata_d, rdata_q;
  logic             unused_bits;

  assign unused_bits = ^wdata_i[27:16];

  gpio_pad_sync #(.W(NPAD)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (rx_sync)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    for (genvar p = 0; p < PADS_MAX; p++) begin : g_pad
      localparam int IDX = g * PADS_MAX + p;
      localparam logic [ADDR_W-1:0] A0 = pad_cfg_addr(g, p);
      localparam logic [ADDR_W-1:0] A1 = A0 + ADDR_W'(4);
      if (p < int'(GROUP_PADS[g*4 +: 4])) begin : g_impl
        logic             tx_r, inv_r;
        logic [SEL_W-1:0] sel_r;
        logic [2:0]       mode_r;

        assign hit0[IDX] = (addr_i == A0);
        assign hit1[IDX] = (addr_i == A1);

        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            tx_r   <= 1'b0;
            sel_r  <= '0;
            mode_r <= '0;
            inv_r  <= 1'b0;
          end else if (we_i) begin
            if (hit0[IDX]) begin
              tx_r  <= wdata_i[1];
              sel_r <= wdata_i[31:28];
            end
            if (hit1[IDX]) begin
              mode_r <= wdata_i[2:0];
              inv_r  <= wdata_i[6];
            end
          end
        end

        gpio_pad_event u_evt (
          .clk_i (clk_i),
          .rst_ni(rst_ni),
          .rx_i  (rx_sync[IDX]),
          .inv_i (inv_r),
          .mode_i(mode_r),
          .evt_o (evt[IDX])
        );

        assign tx_vec[IDX]   = tx_r;
        assign inv_vec[IDX]  = inv_r;
        assign sel_arr[IDX]  = sel_r;
        assign mode_arr[IDX] = mode_r;
      end else begin : g_none
        assign hit0[IDX]     = 1'b0;
        assign hit1[IDX]     = 1'b0;
        assign evt[IDX]      = 1'b0;
        assign tx_vec[IDX]   = 1'b0;
        assign inv_vec[IDX]  = 1'b0;
        assign sel_arr[IDX]  = '0;
        assign mode_arr[IDX] = '0;
      end
    end
  end

  assign pad_out_o = tx_vec;

  // route pad events onto shared lines
  always_comb begin
    line_set = '0;
    for (int i = 0; i < NPAD; i++)
      if (evt[i]) line_set[sel_arr[i]] = 1'b1;
  end

  gpio_irq_ctrl #(.N(LINES)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (line_set),
    .clr_we_i (we_i && addr_i == STAT_ADDR),
    .mask_we_i(we_i && addr_i == MASK_ADDR),
    .wdata_i  (wdata_i[LINES-1:0]),
    .status_o (stat_q),
    .mask_o   (mask_q),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_d = '0;
    if (addr_i == STAT_ADDR) rdata_d[LINES-1:0] = stat_q;
    if (addr_i == MASK_ADDR) rdata_d[LINES-1:0] = mask_q;
    for (int i = 0; i < NPAD; i++) begin
      if (hit0[i]) rdata_d = rdata_d | {sel_arr[i], 26'b0, tx_vec[i], rx_sync[i]};
      if (hit1[i]) rdata_d = rdata_d | {25'b0, inv_vec[i], 3'b0, mode_arr[i]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/gpio_pad_ctrl_chk.sv
module gpio_pad_ctrl_chk
  import gpio_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              irq_o,
  input logic              pad_out0_i,
  input logic [LINES-1:0]  status_i,
  input logic [LINES-1:0]  mask_i,
  input logic [LINES-1:0]  line_set_i
);
  // R10
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|(status_i & mask_i)));

  // R10
  mask_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == MASK_ADDR) |=> mask_i == $past(wdata_i[LINES-1:0]));

  // R2
  tx_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == PAD_BASE) |=> pad_out0_i == $past(wdata_i[1]));

  // R9
  status_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == STAT_ADDR) |=> (status_i & $past(status_i)) == $past(status_i));

  // R4
  status_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i & ~$past(status_i) & ~$past(line_set_i)) == '0);
endmodule

bind gpio_pad_ctrl gpio_pad_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .irq_o     (irq_o),
  .pad_out0_i(pad_out_o[0]),
  .status_i  (stat_q),
  .mask_i    (mask_q),
  .line_set_i(line_set)
);

// File: tb/tb_gpio_pad_ctrl.sv
module tb_gpio_pad_ctrl;
  localparam int NPAD = 45;
  localparam logic [15:0] ST = 16'h0300, MK = 16'h0380;
  localparam logic [15:0] P0W0 = 16'h4400, P0W1 = 16'h4404;   // group 0 pad 0
  localparam logic [15:0] P16W0 = 16'h4808, P16W1 = 16'h480C; // group 1 pad 1
  localparam logic [15:0] U9W0 = 16'h4448, U9W1 = 16'h444C;   // group 0 pad 9, not fitted
  localparam logic [15:0] P7W0 = 16'h4438;                    // group 0 pad 7, last fitted

  logic clk = 1'b0, rst_ni = 1'b0, we = 1'b0, re = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NPAD-1:0] pad_in = '0, pad_out;
  logic irq;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #5ns clk = ~clk;

  gpio_pad_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .re_i(re), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out),
    .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0; addr = '0; d = rdata;
  endtask

  task automatic pad(input int i, input logic v);
    @(negedge clk); pad_in[i] = v;
    wcyc(5);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 pad_out", 32'(pad_out), 0);
    rd(ST, d);   chk("R1 status", d, 0);
    rd(MK, d);   chk("R1 mask", d, 0);
    rd(P0W0, d); chk("R1 word0", d, 0);
    rd(P0W1, d); chk("R1 word1", d, 0);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    wr(P16W0, 32'hF000_0003);
    rd(P16W0, d); chk("R2 word0 readback", d, 32'hF000_0002);
    chk("R2 pad_out", {31'b0, pad_out[16]}, 1);
    wr(P16W1, 32'hFFFF_FFFF);
    rd(P16W1, d); chk("R3 word1 readback", d, 32'h0000_0047);
    pad(16, 1'b1);
    rd(P16W0, d); chk("R2 rx bit", d, 32'hF000_0003);
    rd(ST, d);    chk("R12 code 7 no event", d, 0);
    wr(P16W1, 0); wr(P16W0, 0);
    pad(16, 1'b0);
    rd(ST, d);    chk("R12 status quiet", d, 0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    wr(P0W0, 32'h5000_0000); wr(P0W1, 2);
    pad(0, 1'b1);
    rd(ST, d); chk("R4 rise sets line 5", d, 32'h20);
    chk("R10 masked irq low", {31'b0, irq}, 0);
    wr(ST, 32'h20);
    pad(0, 1'b0);
    rd(ST, d); chk("R4 fall ignored", d, 0);
  endtask

  task automatic t_fall();
    logic [31:0] d;
    wr(P0W1, 0); pad(0, 1'b1);
    wr(P0W1, 1);
    rd(ST, d); chk("R5 no event while high", d, 0);
    pad(0, 1'b0);
    rd(ST, d); chk("R5 fall sets", d, 32'h20);
    wr(ST, 32'h20);
  endtask

  task automatic t_both();
    logic [31:0] d;
    wr(P0W1, 3);
    pad(0, 1'b1);
    rd(ST, d); chk("R6 rise", d, 32'h20);
    wr(ST, 32'h20);
    rd(ST, d); chk("R6 cleared", d, 0);
    pad(0, 1'b0);
    rd(ST, d); chk("R6 fall", d, 32'h20);
    wr(ST, 32'h20);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(P0W1, 4);
    pad(0, 1'b1);
    rd(ST, d); chk("R7 level set", d, 32'h20);
    wr(ST, 32'h20);
    rd(ST, d); chk("R7 re-set while high", d, 32'h20);
    pad(0, 1'b0);
    wr(ST, 32'h20);
    rd(ST, d); chk("R7 clear holds when low", d, 0);
  endtask

  task automatic t_inv();
    logic [31:0] d;
    wr(P0W1, 32'h44);
    wcyc(3);
    rd(ST, d); chk("R8 inverted level fires low", d, 32'h20);
    pad(0, 1'b1);
    wr(ST, 32'h20);
    rd(ST, d); chk("R8 quiet when high", d, 0);
    wr(P0W1, 0);
    pad(0, 1'b0);
    wr(ST, 32'hFFFF);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(P16W0, 32'h9000_0000); wr(P16W1, 2); wr(P0W1, 2);
    @(negedge clk); pad_in[0] = 1'b1; pad_in[16] = 1'b1;
    wcyc(5);
    rd(ST, d); chk("R9 two lines", d, 32'h220);
    wr(ST, 32'h20);
    rd(ST, d); chk("R9 clear one", d, 32'h200);
    wr(ST, 0);
    rd(ST, d); chk("R9 zero write keeps", d, 32'h200);
    wr(ST, 32'h200);
    rd(ST, d); chk("R9 clear other", d, 0);
    @(negedge clk); pad_in[0] = 1'b0; pad_in[16] = 1'b0;
    wcyc(5);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(MK, 32'h20);
    rd(MK, d); chk("R10 mask readback", d, 32'h20);
    pad(0, 1'b1);
    chk("R10 irq high", {31'b0, irq}, 1);
    wr(MK, 32'h200);
    wcyc(2);
    chk("R10 irq drops when masked", {31'b0, irq}, 0);
    wr(MK, 32'h20);
    wcyc(2);
    chk("R10 irq back", {31'b0, irq}, 1);
    wr(ST, 32'h20);
    wcyc(2);
    chk("R10 irq after clear", {31'b0, irq}, 0);
    wr(MK, 0);
    pad(0, 1'b0);
  endtask

  task automatic t_unimpl();
    logic [31:0] d;
    wr(U9W0, 32'hF000_0002); wr(U9W1, 32'h44);
    rd(U9W0, d); chk("R11 absent word0", d, 0);
    rd(U9W1, d); chk("R11 absent word1", d, 0);
    chk("R11 absent pad_out", {31'b0, pad_out[9]}, 0);
    rd(16'h1234, d); chk("R11 unmapped", d, 0);
    wr(P7W0, 32'h2);
    rd(P7W0, d); chk("R2 last fitted pad", d, 32'h2);
    wr(P7W0, 0);
  endtask

  task automatic t_mode_off();
    logic [31:0] d;
    wr(P0W1, 0);
    pad(0, 1'b1); pad(0, 1'b0);
    rd(ST, d); chk("R12 code 0", d, 0);
    wr(P0W1, 5);
    pad(0, 1'b1); pad(0, 1'b0);
    rd(ST, d); chk("R12 code 5", d, 0);
    wr(P0W1, 0);
  endtask

  initial begin
    wcyc(3);
    @(negedge clk); rst_ni = 1'b1;
    wcyc(2);
    t_reset();
    t_cfg();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_inv();
    t_w1c();
    t_mask();
    t_unimpl();
    t_mode_off();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule